// File: doc/BRIEF.md
# IDE PIO timing controller

This block runs programmed-I/O cycles on one parallel IDE channel with two attached devices. The host raises a request with a direction, a target device and a choice between the data port and one of the command-block registers. The block then drives the drive-side register address, the chip select and the read or write strobe. Strobe and recovery widths come from a timing set chosen by the target device and the access kind, so a fast and a slow device can share the channel.

A data-port access carries 32 host bits and becomes two 16-bit drive transfers, low half first. A command-block access is a single 16-bit transfer. Four timing sets (two per device, one for data and one for command accesses) are written through a small configuration port. A drive reset output is held low while the block is in reset and is then set by software.

Top module: `ide_pio_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, `cs_n_o`, `rd_n_o` and `wr_n_o` are high, `ack_o` and `dd_oe_o` are low.
- R2: All four timing sets reset to 255 strobe cycles and 255 recovery cycles.
- R3: Each transfer is one setup cycle (`cs_n_o` low, strobes high), then the strobe low for the strobe count, then one hold cycle (`cs_n_o` low, strobes high), then `cs_n_o` high for the recovery count; `rd_n_o` is used for reads, `wr_n_o` for writes.
- R4: The timing set is picked by `{dev_i, cmd_i}` at acceptance (index 0: device 0 data, 1: device 0 command, 2: device 1 data, 3: device 1 command), and each set is written on its own via `cfg_we_i` with `{cfg_dev_i, cfg_cmd_i}`.
- R5: With `cmd_i` low the access makes two transfers with `da_o` = 0; with `cmd_i` high it makes one transfer with `da_o` = `addr_i`, and read data bits 31:16 are zero.
- R6: Read data is taken from `dd_i` on the clock edge that ends the last strobe-low cycle; the first transfer fills `rdata_o[15:0]`, the second `rdata_o[31:16]`, valid while `ack_o` is high.
- R7: For writes `dd_oe_o` is high from setup through hold and `dd_o` carries `wdata_i[15:0]` in the first transfer and `wdata_i[31:16]` in the second; for reads `dd_oe_o` stays low.
- R8: `ack_o` is high for exactly one cycle, the cycle after the last recovery cycle; a request is accepted only when the block is idle.
- R9: A programmed count of zero acts as one cycle.
- R10: `drv_rst_n_o` is low during reset and stays low until written; a write with `drst_we_i` sets it to `drst_val_i` from the next cycle.
- R11: The timing set is captured at acceptance; a configuration write during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ack_o` |
| we_i | input | 1 | 1 write, 0 read |
| cmd_i | input | 1 | 1 command-block register, 0 data port |
| dev_i | input | 1 | Target device |
| addr_i | input | 3 | Command-block register address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data |
| cfg_we_i | input | 1 | Timing set write enable |
| cfg_dev_i | input | 1 | Device of the timing set |
| cfg_cmd_i | input | 1 | 1 command set, 0 data set |
| cfg_act_i | input | 8 | Strobe-low cycles |
| cfg_rec_i | input | 8 | Recovery cycles |
| drst_we_i | input | 1 | Drive reset write enable |
| drst_val_i | input | 1 | Drive reset level to write |
| drv_rst_n_o | output | 1 | Drive reset, active low |
| da_o | output | 3 | Drive register address |
| cs_n_o | output | 1 | Drive chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Drive data out |
| dd_i | input | 16 | Drive data in |
| dd_oe_o | output | 1 | Drive data output enable |

## Verification
Accesses are issued under the reset timing, under four distinct programmed sets mixing short and long strobe and recovery counts, and with zero counts, so a swapped set index, an off-by-one count or a missing clamp each shows as a shifted edge against the per-cycle model. Reads and writes alternate over data and command accesses to separate the two-transfer split, half ordering and address choice. The drive model changes `dd_i` on every strobe-low cycle, so latching on any edge but the last returns a distinct word. A configuration write landing mid-access tells capture at acceptance apart from live use of the registers.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_RECOV, ST_ACK
  } seq_st_e;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } tim_t;

  function automatic tim_t clamp_tim(tim_t v);
    tim_t r;
    r = v;
    if (v.act == '0) r.act = CNT_W'(1);
    if (v.rec == '0) r.rec = CNT_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/ide_pio_tim_regs.sv
module ide_pio_tim_regs
  import ide_pio_pkg::*;
#(
  parameter int NDEV  = 2,
  localparam int NSET  = 2 * NDEV,
  localparam int SEL_W = $clog2(NSET)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  tim_t             wr_val_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output tim_t             rd_val_o
);
  tim_t set_q [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) set_q[g] <= '1;
      else if (wr_en_i && wr_sel_i == SEL_W'(g)) set_q[g] <= clamp_tim(wr_val_i);
    end
  end

  assign rd_val_o = set_q[rd_sel_i];
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    two_half_i,
  input  tim_t    tim_i,
  output seq_st_e st_o,
  output logic    half_o,
  output logic    accept_o,
  output logic    last_act_o,
  output logic    ack_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_SETUP;
          half_q <= 1'b0;
        end
        ST_SETUP: begin
          st_q  <= ST_ACTIVE;
          cnt_q <= tim_i.act - CNT_W'(1);
        end
        ST_ACTIVE: begin
          if (cnt_q == '0) st_q <= ST_HOLD;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_HOLD: begin
          st_q  <= ST_RECOV;
          cnt_q <= tim_i.rec - CNT_W'(1);
        end
        ST_RECOV: begin
          if (cnt_q == '0) begin
            if (two_half_i && !half_q) begin
              st_q   <= ST_SETUP;
              half_q <= 1'b1;
            end else begin
              st_q <= ST_ACK;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign half_o     = half_q;
  assign accept_o   = (st_q == ST_IDLE) && req_i;
  assign last_act_o = (st_q == ST_ACTIVE) && (cnt_q == '0);
  assign ack_o      = (st_q == ST_ACK);
endmodule

// File: rtl/ide_pio_dpath.sv
module ide_pio_dpath #(
  parameter int DRV_W  = 16,
  localparam int HOST_W = 2 * DRV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic              half_i,
  input  logic              latch_i,
  input  logic [DRV_W-1:0]  dd_i,
  output logic [DRV_W-1:0]  dd_o,
  output logic [HOST_W-1:0] rdata_o
);
  logic [HOST_W-1:0] wdata_q;
  logic [HOST_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept_i) begin
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (latch_i) begin
      if (half_i) rdata_q[HOST_W-1:DRV_W] <= dd_i;
      else        rdata_q[DRV_W-1:0]      <= dd_i;
    end
  end

  assign dd_o    = half_i ? wdata_q[HOST_W-1:DRV_W] : wdata_q[DRV_W-1:0];
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
#(
  parameter int NDEV   = 2,
  parameter int ADDR_W = 3,
  parameter int DRV_W  = 16,
  localparam int HOST_W = 2 * DRV_W,
  localparam int DEV_W  = $clog2(NDEV),
  localparam int SEL_W  = DEV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              cmd_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [HOST_W-1:0] rdata_o,
  input  logic              cfg_we_i,
  input  logic [DEV_W-1:0]  cfg_dev_i,
  input  logic              cfg_cmd_i,
  input  logic [CNT_W-1:0]  cfg_act_i,
  input  logic [CNT_W-1:0]  cfg_rec_i,
  input  logic              drst_we_i,
  input  logic              drst_val_i,
  output logic              drv_rst_n_o,
  output logic [ADDR_W-1:0] da_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DRV_W-1:0]  dd_o,
  input  logic [DRV_W-1:0]  dd_i,
  output logic              dd_oe_o
);
  tim_t              tim_rd, tim_q, cfg_val;
  seq_st_e           st;
  logic              half, accept, last_act;
  logic              we_q, cmd_q, drst_q;
  logic [ADDR_W-1:0] addr_q;
  logic              in_win;

  assign cfg_val = '{act: cfg_act_i, rec: cfg_rec_i};

  ide_pio_tim_regs #(.NDEV(NDEV)) u_tim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (cfg_we_i),
    .wr_sel_i ({cfg_dev_i, cfg_cmd_i}),
    .wr_val_i (cfg_val),
    .rd_sel_i ({dev_i, cmd_i}),
    .rd_val_o (tim_rd)
  );

  // request attributes and timing frozen for the whole access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q  <= '1;
      we_q   <= 1'b0;
      cmd_q  <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      tim_q  <= tim_rd;
      we_q   <= we_i;
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
    end
  end

  ide_pio_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .two_half_i (!cmd_q),
    .tim_i      (tim_q),
    .st_o       (st),
    .half_o     (half),
    .accept_o   (accept),
    .last_act_o (last_act),
    .ack_o      (ack_o)
  );

  ide_pio_dpath #(.DRV_W(DRV_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .wdata_i  (wdata_i),
    .half_i   (half),
    .latch_i  (last_act && !we_q),
    .dd_i     (dd_i),
    .dd_o     (dd_o),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        drst_q <= 1'b0;
    else if (drst_we_i) drst_q <= drst_val_i;
  end

  assign in_win      = (st == ST_SETUP) || (st == ST_ACTIVE) || (st == ST_HOLD);
  assign cs_n_o      = !in_win;
  assign rd_n_o      = !((st == ST_ACTIVE) && !we_q);
  assign wr_n_o      = !((st == ST_ACTIVE) && we_q);
  assign dd_oe_o     = in_win && we_q;
  assign da_o        = cmd_q ? addr_q : '0;
  assign drv_rst_n_o = drst_q;
endmodule

// File: rtl/ide_pio_ctrl_chk.sv
module ide_pio_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic dd_oe_o,
  input logic drv_rst_n_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_o || wr_n_o); // R3
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !cs_n_o); // R3
  AST_CS_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> $past(!cs_n_o)); // R3
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_n_o) || $rose(wr_n_o)) |-> !cs_n_o); // R3
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R8
  AST_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (cs_n_o && rd_n_o && wr_n_o)); // R8
  AST_OE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> dd_oe_o); // R7
  AST_OE_OFF_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !dd_oe_o); // R7

  always @(negedge clk_i) begin
    if (!rst_ni) AST_DRST_LOW: assert (!drv_rst_n_o); // R10
  end
endmodule

bind ide_pio_ctrl ide_pio_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .cs_n_o      (cs_n_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .dd_oe_o     (dd_oe_o),
  .drv_rst_n_o (drv_rst_n_o)
);

// File: tb/ide_pio_ctrl_tb.sv
module ide_pio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0, cmd = 0, dev = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        ack;
  logic [31:0] rdata;
  logic        cfg_we = 0, cfg_dev = 0, cfg_cmd = 0;
  logic [7:0]  cfg_act = 0, cfg_rec = 0;
  logic        drst_we = 0, drst_val = 0;
  logic        drv_rst_n;
  logic [2:0]  da;
  logic        cs_n, rd_n, wr_n, dd_oe;
  logic [15:0] dd_out, dd_in;

  int n_chk = 0, n_bad = 0;
  bit mon_en = 0;
  string cur_tag = "R3";

  typedef struct packed {
    logic ack, oe, cs_n, rd_n, wr_n;
    logic [2:0]  da;
    logic [15:0] dd;
  } exp_t;
  exp_t q[$];
  int act_m[4], rec_m[4];
  int lowcnt = 0, rd_idx = 0;
  bit prev_low = 0;

  always #4 clk = ~clk;

  ide_pio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cmd_i(cmd),
    .dev_i(dev), .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .cfg_we_i(cfg_we), .cfg_dev_i(cfg_dev), .cfg_cmd_i(cfg_cmd),
    .cfg_act_i(cfg_act), .cfg_rec_i(cfg_rec), .drst_we_i(drst_we),
    .drst_val_i(drst_val), .drv_rst_n_o(drv_rst_n), .da_o(da), .cs_n_o(cs_n),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .dd_o(dd_out), .dd_i(dd_in), .dd_oe_o(dd_oe)
  );

  // drive model: word changes on every strobe-low cycle
  assign dd_in = rd_n ? 16'h0000 : ({(rd_idx[0] ? 8'h5C : 8'hA3), 8'h00} + 16'(lowcnt));

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e;
      logic [7:0] g, x;
      if (q.size() > 0) e = q.pop_front();
      else e = '{ack: 0, oe: 0, cs_n: 1, rd_n: 1, wr_n: 1, da: 0, dd: 0};
      g = {ack, dd_oe, cs_n, rd_n, wr_n, (e.cs_n ? 3'd0 : da)};
      x = {e.ack, e.oe, e.cs_n, e.rd_n, e.wr_n, (e.cs_n ? 3'd0 : e.da)};
      check(g == x, {"R3 R8 ", cur_tag, " pins"}, {24'h0, g}, {24'h0, x});
      if (e.oe) check(dd_out == e.dd, {"R7 ", cur_tag, " dd_o"}, {16'h0, dd_out}, {16'h0, e.dd});
    end
    if (!rd_n) begin
      lowcnt++;
      prev_low = 1;
    end else begin
      if (prev_low) rd_idx++;
      prev_low = 0;
      lowcnt = 0;
    end
  end

  task automatic cfg_set(bit d, bit c, int a, int r);
    @(posedge clk); #1;
    cfg_we = 1; cfg_dev = d; cfg_cmd = c; cfg_act = 8'(a); cfg_rec = 8'(r);
    act_m[d*2+c] = (a == 0) ? 1 : a;
    rec_m[d*2+c] = (r == 0) ? 1 : r;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic access(bit w, bit c, bit d, logic [2:0] ad, logic [31:0] wd, string tag);
    int a, r, nh;
    logic [2:0] eda;
    logic [31:0] exp_rd;
    @(posedge clk); #1;
    cur_tag = tag;
    req = 1; we = w; cmd = c; dev = d; addr = ad; wdata = wd; rd_idx = 0;
    a = act_m[d*2+c]; r = rec_m[d*2+c];
    nh = c ? 1 : 2;
    eda = c ? ad : 3'd0;
    q.push_back('{ack: 0, oe: 0, cs_n: 1, rd_n: 1, wr_n: 1, da: 0, dd: 0});
    for (int h = 0; h < nh; h++) begin
      logic [15:0] wv;
      wv = h ? wd[31:16] : wd[15:0];
      q.push_back('{ack: 0, oe: w, cs_n: 0, rd_n: 1, wr_n: 1, da: eda, dd: wv});
      for (int i = 0; i < a; i++)
        q.push_back('{ack: 0, oe: w, cs_n: 0, rd_n: w, wr_n: !w, da: eda, dd: wv});
      q.push_back('{ack: 0, oe: w, cs_n: 0, rd_n: 1, wr_n: 1, da: eda, dd: wv});
      for (int i = 0; i < r; i++)
        q.push_back('{ack: 0, oe: 0, cs_n: 1, rd_n: 1, wr_n: 1, da: 0, dd: 0});
    end
    q.push_back('{ack: 1, oe: 0, cs_n: 1, rd_n: 1, wr_n: 1, da: 0, dd: 0});
    do @(negedge clk); while (!ack);
    req = 0;
    if (!w) begin
      exp_rd[15:0]  = 16'hA300 + 16'(a);
      exp_rd[31:16] = c ? 16'h0 : (16'h5C00 + 16'(a));
      check(rdata == exp_rd, {(c ? "R5 " : "R6 "), tag, " rdata"}, rdata, exp_rd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: no completion, got timeout expected ack");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin act_m[i] = 255; rec_m[i] = 255; end
    repeat (3) @(negedge clk);
    check(cs_n && rd_n && wr_n && !ack && !dd_oe, "R1 reset pins",
          {27'h0, cs_n, rd_n, wr_n, ack, dd_oe}, 32'h1C);
    check(!drv_rst_n, "R10 drive reset in reset", {31'h0, drv_rst_n}, 32'h0);
    @(posedge clk); #1 rst_n = 1; mon_en = 1;
    @(negedge clk);
    check(cs_n && rd_n && wr_n && !ack && !dd_oe, "R1 after release",
          {27'h0, cs_n, rd_n, wr_n, ack, dd_oe}, 32'h1C);
    check(!drv_rst_n, "R10 drive reset held", {31'h0, drv_rst_n}, 32'h0);
    @(posedge clk); #1 drst_we = 1; drst_val = 1;
    @(posedge clk); #1 drst_we = 0;
    @(negedge clk);
    check(drv_rst_n, "R10 drive reset high", {31'h0, drv_rst_n}, 32'h1);

    access(0, 0, 0, 3'd0, 32'h0, "R2");
    access(1, 1, 1, 3'd6, 32'h0000_00E7, "R2");

    cfg_set(0, 0, 3, 2);
    cfg_set(0, 1, 5, 4);
    cfg_set(1, 0, 1, 1);
    cfg_set(1, 1, 2, 6);
    access(0, 0, 0, 3'd0, 32'h0, "R4");
    access(1, 0, 0, 3'd0, 32'hBEEF_1234, "R4");
    access(0, 1, 0, 3'd7, 32'h0, "R5");
    access(1, 1, 1, 3'd3, 32'h0000_0055, "R5");
    access(0, 0, 1, 3'd0, 32'h0, "R6");
    access(1, 0, 1, 3'd0, 32'hCAFE_F00D, "R7");

    cfg_set(1, 0, 0, 0);
    access(0, 0, 1, 3'd0, 32'h0, "R9");
    cfg_set(0, 1, 0, 5);
    access(1, 1, 0, 3'd2, 32'h0000_00A5, "R9");

    fork
      access(0, 0, 0, 3'd0, 32'h0, "R11");
      begin
        repeat (3) @(posedge clk);
        cfg_set(0, 0, 9, 9);
      end
    join
    access(0, 0, 0, 3'd0, 32'h0, "R11");

    @(posedge clk); #1 drst_we = 1; drst_val = 0;
    @(posedge clk); #1 drst_we = 0;
    @(negedge clk);
    check(!drv_rst_n, "R10 drive reset low again", {31'h0, drv_rst_n}, 32'h0);

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule